// File: doc/BRIEF.md
# Sixteen-Bit Multifunction Combinational ALU

This block is a clock-free arithmetic and logic unit for a datapath. Two operand buses and a four-bit operation code go in. A result bus, a carry-out and a zero flag come out in the same cycle, with no state kept between operations.

The operations are:
- add, subtract, increment and decrement, all on one ripple-carry adder built from four-bit slices;
- bitwise AND, OR and complement;
- left and right shifts through a logarithmic barrel network, with the distance taken from the low bits of the second operand;
- a signed set-less-than that reuses the subtract path.

Codes that name no operation return a zero result. The enclosing datapath places the unit between its register reads and its writeback.

Top module: `comb_alu`

## Requirements
- R1: Code 0000 gives S = (A + B) mod 2^16, and Cout is the carry out of bit 15 of that sum.
- R2: Code 0001 gives S = (A - B) mod 2^16, computed as A + ~B + 1. Cout is the carry of that sum, which is 1 exactly when A >= B as unsigned values.
- R3: Code 0010 gives S = A & B, and code 0011 gives S = A | B, bit by bit.
- R4: Code 0110 gives S = ~A.
- R5: Code 0100 gives S = A + 1, with Cout = 1 only for A = 0xFFFF. Code 0101 gives S = A - 1, computed as A + 0xFFFF, with Cout = 0 only for A = 0x0000.
- R6: Codes 1100 and 1000 both shift A left by B[3:0] places (0 to 15) and fill with zeros. B[15:4] has no effect.
- R7: Code 1110 shifts A right by B[3:0] places and fills the vacated upper bits with zeros.
- R8: Code 1010 shifts A right by B[3:0] places and copies A[15] into the vacated upper bits.
- R9: Code 1001 gives S = 1 when A < B as two's-complement signed values, and S = 0 otherwise.
- R10: Cout is 0 for every code except 0000, 0001, 0100 and 0101.
- R11: The zero output is 1 exactly when S is 0x0000.
- R12: Codes 0111, 1011, 1101 and 1111 give S = 0, Cout = 0 and zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; the value that is shifted, incremented, decremented or complemented |
| b_i | input | 16 | Second operand; its bits [3:0] give the shift distance |
| op_i | input | 4 | Operation code |
| s_o | output | 16 | Result |
| cout_o | output | 1 | Adder carry-out for the arithmetic codes, 0 otherwise |
| zero_o | output | 1 | High when the result is zero |

## Verification
The bench uses the default parameters: a 16-bit word split into four 4-bit carry slices. At this width every shift distance from 0 to 15 can be reached, including the full-width 15-place shifts. Directed operands such as 0xFFFF + 1 and 0x8000 against 0x7FFF drive a carry through all four slices and reach the signed-overflow corner of the comparison. Random operands with set upper B bits confirm that only B[3:0] steers the shifter.

// File: rtl/calu_pkg.sv
package calu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'b0000,
    OP_SUB = 4'b0001,
    OP_AND = 4'b0010,
    OP_OR  = 4'b0011,
    OP_INC = 4'b0100,
    OP_DEC = 4'b0101,
    OP_NOT = 4'b0110,
    OP_SLA = 4'b1000,
    OP_SLT = 4'b1001,
    OP_SRA = 4'b1010,
    OP_SLL = 4'b1100,
    OP_SRL = 4'b1110
  } calu_op_e;

endpackage

// File: rtl/calu_ripple_add.sv
module calu_ripple_add #(
  parameter int WIDTH = 16,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  localparam int NSL = WIDTH / SLICE;

  logic [NSL:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    logic [SLICE:0] part;
    assign part = {1'b0, x_i[g*SLICE +: SLICE]}
                + {1'b0, y_i[g*SLICE +: SLICE]}
                + {{SLICE{1'b0}}, carry[g]};
    assign sum_o[g*SLICE +: SLICE] = part[SLICE-1:0];
    assign carry[g+1] = part[SLICE];
  end

  assign cout_o = carry[NSL];

endmodule

// File: rtl/calu_barrel.sv
module calu_barrel #(
  parameter int WIDTH = 16,
  parameter int SHW   = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din_i,
  input  logic [SHW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] dout_o
);

  logic             fill;
  logic [WIDTH-1:0] din_rev;
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] res_rev;
  logic [WIDTH-1:0] stg [0:SHW];

  // sign fill only applies to right shifts
  assign fill = arith_i & ~left_i & din_i[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign din_rev[i] = din_i[WIDTH-1-i];
    assign res_rev[i] = stg[SHW][WIDTH-1-i];
  end

  assign src    = left_i ? din_rev : din_i;
  assign stg[0] = src;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{D{fill}}, stg[k][WIDTH-1:D]} : stg[k];
  end

  assign dout_o = left_i ? res_rev : stg[SHW];

endmodule

// File: rtl/calu_bitwise.sv
module calu_bitwise #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] y_o
);

  always_comb begin
    unique case (sel_i)
      2'd0:    y_o = a_i & b_i;
      2'd1:    y_o = a_i | b_i;
      2'd2:    y_o = ~a_i;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/comb_alu.sv
module comb_alu
  import calu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SLICE = 4,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       op_i,
  output logic [WIDTH-1:0] s_o,
  output logic             cout_o,
  output logic             zero_o
);

  logic [WIDTH-1:0] add_y;
  logic             add_cin;
  logic             arith_op;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic [1:0]       bw_sel;
  logic [WIDTH-1:0] bw_res;
  logic             sh_left;
  logic             sh_arith;
  logic [WIDTH-1:0] sh_res;
  logic             ovf;
  logic             lt;
  logic [WIDTH-1:0] res;

  // adder operand steering
  always_comb begin
    add_y    = b_i;
    add_cin  = 1'b0;
    arith_op = 1'b0;
    case (op_i)
      OP_ADD: begin add_y = b_i;  add_cin = 1'b0; arith_op = 1'b1; end
      OP_SUB: begin add_y = ~b_i; add_cin = 1'b1; arith_op = 1'b1; end
      OP_SLT: begin add_y = ~b_i; add_cin = 1'b1; end
      OP_INC: begin add_y = '0;   add_cin = 1'b1; arith_op = 1'b1; end
      OP_DEC: begin add_y = '1;   add_cin = 1'b0; arith_op = 1'b1; end
      default: ;
    endcase
  end

  calu_ripple_add #(.WIDTH(WIDTH), .SLICE(SLICE)) u_add (
    .x_i   (a_i),
    .y_i   (add_y),
    .cin_i (add_cin),
    .sum_o (add_sum),
    .cout_o(add_cout)
  );

  always_comb begin
    case (op_i)
      OP_AND:  bw_sel = 2'd0;
      OP_OR:   bw_sel = 2'd1;
      OP_NOT:  bw_sel = 2'd2;
      default: bw_sel = 2'd3;
    endcase
  end

  calu_bitwise #(.WIDTH(WIDTH)) u_bw (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(bw_sel),
    .y_o  (bw_res)
  );

  assign sh_left  = (op_i == OP_SLL) || (op_i == OP_SLA);
  assign sh_arith = (op_i == OP_SRA);

  calu_barrel #(.WIDTH(WIDTH), .SHW(SHW)) u_sh (
    .din_i  (a_i),
    .amt_i  (b_i[SHW-1:0]),
    .left_i (sh_left),
    .arith_i(sh_arith),
    .dout_o (sh_res)
  );

  // signed compare from the subtract result, corrected for overflow
  assign ovf = (a_i[WIDTH-1] ^ b_i[WIDTH-1]) & (add_sum[WIDTH-1] ^ a_i[WIDTH-1]);
  assign lt  = add_sum[WIDTH-1] ^ ovf;

  always_comb begin
    case (op_i)
      OP_ADD, OP_SUB, OP_INC, OP_DEC:     res = add_sum;
      OP_AND, OP_OR, OP_NOT:              res = bw_res;
      OP_SLL, OP_SLA, OP_SRL, OP_SRA:     res = sh_res;
      OP_SLT:                             res = {{(WIDTH-1){1'b0}}, lt};
      default:                            res = '0;
    endcase
  end

  assign s_o    = res;
  assign cout_o = arith_op & add_cout;
  assign zero_o = ~|res;

endmodule

// File: rtl/calu_checker.sv
module calu_checker #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] s_o,
  input logic             cout_o,
  input logic             zero_o
);

  logic [WIDTH:0] wide_sum;
  assign wide_sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    if (op_i == 4'b0000)
      AST_ADD_SUM: assert ({cout_o, s_o} == wide_sum) else $error("add mismatch"); // R1
    if (op_i == 4'b0110)
      AST_NOT_INVERTS: assert ((s_o ^ a_i) == {WIDTH{1'b1}}) else $error("not mismatch"); // R4
    if (op_i == 4'b1001)
      AST_SLT_ONE_BIT: assert (s_o[WIDTH-1:1] == '0) else $error("slt upper bits"); // R9
    if (op_i[3] || op_i == 4'b0010 || op_i == 4'b0011 || op_i == 4'b0110 || op_i == 4'b0111)
      AST_NO_CARRY_OTHER: assert (!cout_o) else $error("carry on non-arith op"); // R10
    if (zero_o)
      AST_ZERO_MEANS_NULL: assert (s_o == '0) else $error("zero with nonzero result"); // R11
    if (op_i == 4'b0111 || op_i == 4'b1011 || op_i == 4'b1101 || op_i == 4'b1111)
      AST_UNDEF_CLEAR: assert (zero_o && !cout_o) else $error("undefined op output"); // R12
    if (op_i == 4'b1110 && b_i[3:0] == 4'd0)
      AST_SRL_BY_ZERO: assert (s_o == a_i) else $error("shift by zero changed A"); // R7
  end

endmodule

bind comb_alu calu_checker #(.WIDTH(WIDTH)) u_calu_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .op_i  (op_i),
  .s_o   (s_o),
  .cout_o(cout_o),
  .zero_o(zero_o)
);

// File: tb/comb_alu_bench.sv
module comb_alu_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic [3:0]   op;
  logic [W-1:0] s;
  logic         cout, zero;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  comb_alu u_comb_alu (
    .a_i(a), .b_i(b), .op_i(op), .s_o(s), .cout_o(cout), .zero_o(zero)
  );

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010, 4'b0011: return "R3";
      4'b0110: return "R4";
      4'b0100, 4'b0101: return "R5";
      4'b1100, 4'b1000: return "R6";
      4'b1110: return "R7";
      4'b1010: return "R8";
      4'b1001: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] r;
    r = '0;
    case (o)
      4'b0000: r = {1'b0, x} + {1'b0, y};
      4'b0001: r = {1'b0, x} + {1'b0, ~y} + 17'd1;
      4'b0010: r = {1'b0, x & y};
      4'b0011: r = {1'b0, x | y};
      4'b0100: r = {1'b0, x} + 17'd1;
      4'b0101: r = {1'b0, x} + 17'h0FFFF;
      4'b0110: r = {1'b0, ~x};
      4'b1100, 4'b1000: r = {1'b0, x << y[3:0]};
      4'b1110: r = {1'b0, x >> y[3:0]};
      4'b1010: r = {1'b0, W'($signed(x) >>> y[3:0])};
      4'b1001: r = ($signed(x) < $signed(y)) ? 17'd1 : 17'd0;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] e;
    logic       ez;
    @(posedge clk);
    op = o; a = x; b = y;
    @(negedge clk);
    e  = model(o, x, y);
    ez = (e[W-1:0] == '0);
    checks++;
    if (s !== e[W-1:0] || cout !== e[W] || zero !== ez) begin
      errors++;
      $display("FAIL %s (R10/R11 flags) op=%b a=%h b=%h: got s=%h c=%b z=%b, expected s=%h c=%b z=%b",
               req_of(o), o, x, y, s, cout, zero, e[W-1:0], e[W], ez);
    end
  endtask

  initial begin
    op = 4'b0000; a = '0; b = '0;
    // R11 zero flag on an all-zero add
    apply(4'b0000, 16'h0000, 16'h0000);
    // R1 carry through all slices
    apply(4'b0000, 16'hFFFF, 16'h0001);
    apply(4'b0000, 16'h1234, 16'h4321);
    // R2 borrow and equal cases
    apply(4'b0001, 16'h0003, 16'h0005);
    apply(4'b0001, 16'h5555, 16'h5555);
    // R5 wrap corners
    apply(4'b0100, 16'hFFFF, 16'h0000);
    apply(4'b0101, 16'h0000, 16'h0000);
    apply(4'b0101, 16'h0001, 16'h0000);
    // R4 and R3
    apply(4'b0110, 16'hA5A5, 16'h0000);
    apply(4'b0010, 16'hF0F0, 16'h3C3C);
    apply(4'b0011, 16'hF0F0, 16'h3C3C);
    // R6/R7/R8 distances 0 and 15, upper B bits set
    for (int d = 0; d < 16; d++) begin
      apply(4'b1100, 16'h8001, 16'hFFF0 | 16'(d));
      apply(4'b1000, 16'h8001, 16'(d));
      apply(4'b1110, 16'h8001, 16'hABC0 | 16'(d));
      apply(4'b1010, 16'h8001, 16'(d));
      apply(4'b1010, 16'h4001, 16'(d));
    end
    // R9 signed overflow corners
    apply(4'b1001, 16'h8000, 16'h7FFF);
    apply(4'b1001, 16'h7FFF, 16'h8000);
    apply(4'b1001, 16'hFFFF, 16'h0000);
    apply(4'b1001, 16'h0004, 16'h0004);
    // R12 undefined codes with R10 carry checked
    apply(4'b0111, 16'hFFFF, 16'hFFFF);
    apply(4'b1011, 16'hFFFF, 16'hFFFF);
    apply(4'b1101, 16'h1234, 16'h0001);
    apply(4'b1111, 16'h8000, 16'h8000);
    // random mix over every code
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      apply(4'($urandom), 16'($urandom), 16'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule